// File: doc/BRIEF.md
# Configuration Space Access Router

This block terminates a memory-mapped configuration window. It takes one configuration read or write at a time and sends it to one of up to 32 devices, each with up to 8 functions. The block subtracts the window base from the request address. It then splits the low bits of the offset into a device number, a function number and a register byte offset. A presence table holds one bit per device/function slot. Bits are set through a registration port and cleared by reset.

An access of 1, 2 or 4 bytes to a present slot goes out as a single-cycle command on a shared slot port. The command carries a flat slot index, so that the device-side fabric can steer it. The block answers other accesses itself:
- A read of an empty slot returns all-ones of the access width.
- A write to an empty slot returns an error.
- Any other size returns an error.

Every response appears a fixed number of cycles after the request is taken. That number is the product of a latency in bus cycles and a bus clock ratio. The response is held until the requester accepts it. Only one access is in flight at a time.

Top module: `cfgspace_router`

## Requirements
- R1: After reset, every presence bit is clear, `rsp_valid` and `cfg_valid` are low and `req_ready` is high.
- R2: The decode works on the offset `req_addr - WIN_BASE`. The device is offset bits [15:11], the function is bits [10:8] and the register is bits [7:0]. A forwarded command carries `cfg_slot = device*8 + function` and `cfg_reg = register`.
- R3: A read of an absent slot is not forwarded and completes with `rsp_err`=0. Its `rsp_rdata` is 0x000000FF for size 1, 0x0000FFFF for size 2 and 0xFFFFFFFF for size 4.
- R4: A read of a present slot with size 1, 2 or 4 is forwarded.
  - `cfg_valid` is a one-cycle pulse in the cycle after acceptance, with `cfg_write`=0 and `cfg_size` equal to the request size.
  - The response carries `cfg_rdata` of that cycle, masked to its low size bytes, with `rsp_err`=0.
- R5: A write to an absent slot is not forwarded and completes with `rsp_err`=1 and `rsp_rdata`=0.
- R6: A `req_size` other than 1, 2 or 4 is not forwarded and completes with `rsp_err`=1 and `rsp_rdata`=0. This holds for reads and writes, whether or not the slot is present.
- R7: A write of size 1, 2 or 4 to a present slot is forwarded with `cfg_write`=1. `cfg_wdata` is `req_wdata` masked to its low size bytes. The response has `rsp_err`=0 and `rsp_rdata`=0.
- R8: `rsp_valid` rises exactly LAT_CYC*CLK_RATIO clock edges after the edge that accepts the request.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_err` do not change. The handshake edge drops `rsp_valid`.
- R10: `req_ready` is low from the acceptance edge until the edge at which the response is taken, so at most one access is outstanding.
- R11: A `reg_valid` pulse sets the presence bit of slot {`reg_dev`,`reg_func`} at that edge. A request accepted at the same edge still sees the old bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Mark a slot present |
| reg_dev | input | 5 | Device number to register |
| reg_func | input | 3 | Function number to register |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Router idle, request accepted on this edge |
| req_addr | input | 32 | Request address inside the window |
| req_size | input | 3 | Access size in bytes (1, 2, 4 legal) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, low bytes used |
| rsp_valid | output | 1 | Response valid, held until taken |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access was illegal |
| cfg_valid | output | 1 | One-cycle command to a slot |
| cfg_slot | output | 8 | Flat slot index device*8+function |
| cfg_reg | output | 8 | Register byte offset |
| cfg_size | output | 3 | Access size in bytes |
| cfg_write | output | 1 | Command is a write |
| cfg_wdata | output | 32 | Masked write data |
| cfg_rdata | input | 32 | Slot read data, valid while `cfg_valid` is high |

## Verification
Once a request is accepted, results appear at fixed offsets from the accepting edge:
- The slot command appears after one edge.
- The response appears after LAT_CYC*CLK_RATIO edges. The bench builds the router with a ratio of 2 and a latency of 2, so that the count is not the trivial 1.

The behavioural model in the bench steps on the same edges with a countdown set to that product. At every falling edge it compares `req_ready`, `cfg_valid`, `rsp_valid` and, when they are due, the command fields and the response data. A response due one cycle early or late therefore shows up in the exact cycle where it differs.

Responses are left pending for several cycles to exercise the hold rule. A registration is also placed on the same edge as a request to the same slot.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  localparam int CFG_DW = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } rtr_state_e;

  // Byte count encodings that a slot can take.
  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  // Byte-lane mask for a size; zero for illegal sizes.
  function automatic logic [CFG_DW-1:0] lane_mask(input logic [2:0] sz);
    logic [CFG_DW-1:0] m;
    case (sz)
      3'd1:    m = 32'h0000_00FF;
      3'd2:    m = 32'h0000_FFFF;
      3'd4:    m = 32'hFFFF_FFFF;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode #(
  parameter int          ADDR_W   = 32,
  parameter int          DEV_W    = 5,
  parameter int          FUNC_W   = 3,
  parameter int          REG_W    = 8,
  parameter logic [31:0] WIN_BASE = 32'h0
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic [DEV_W-1:0]        dev,
  output logic [FUNC_W-1:0]       func,
  output logic [REG_W-1:0]        regb,
  output logic [DEV_W+FUNC_W-1:0] slot
);
  localparam int FIELD_W = DEV_W + FUNC_W + REG_W;

  logic [FIELD_W-1:0] offset;

  // Low bits of a difference depend only on low bits of the operands.
  always_comb begin
    offset = addr[FIELD_W-1:0] - WIN_BASE[FIELD_W-1:0];
    regb   = offset[REG_W-1:0];
    func   = offset[REG_W+FUNC_W-1:REG_W];
    dev    = offset[FIELD_W-1:REG_W+FUNC_W];
    slot   = {dev, func};
  end
endmodule

// File: rtl/cfgr_presence.sv
module cfgr_presence #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_hit
);
  localparam int N_SLOT = 1 << SLOT_W;

  logic [N_SLOT-1:0] bits_q;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        bits_q[g] <= 1'b0;
      else if (set_en && (set_slot == SLOT_W'(g)))
        bits_q[g] <= 1'b1;
    end
  end

  assign rd_hit = bits_q[rd_slot];
endmodule

// File: rtl/cfgr_delay.sv
module cfgr_delay #(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int LAT_EFF = (LAT < 1) ? 1 : LAT;
  localparam int CNT_W   = (LAT_EFF < 2) ? 1 : $clog2(LAT_EFF);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(LAT_EFF - 1);
    end else if (busy_q) begin
      if (cnt_q == '0)
        busy_q <= 1'b0;
      else
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/cfgspace_router.sv
module cfgspace_router
  import cfgr_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          N_DEV     = 32,
  parameter int          N_FUNC    = 8,
  parameter int          REG_BYTES = 256,
  parameter logic [31:0] WIN_BASE  = 32'h0,
  parameter int          LAT_CYC   = 1,
  parameter int          CLK_RATIO = 1
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     reg_valid,
  input  logic [$clog2(N_DEV)-1:0]                 reg_dev,
  input  logic [$clog2(N_FUNC)-1:0]                reg_func,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic [ADDR_W-1:0]                        req_addr,
  input  logic [2:0]                               req_size,
  input  logic                                     req_write,
  input  logic [31:0]                              req_wdata,
  output logic                                     rsp_valid,
  input  logic                                     rsp_ready,
  output logic [31:0]                              rsp_rdata,
  output logic                                     rsp_err,
  output logic                                     cfg_valid,
  output logic [$clog2(N_DEV)+$clog2(N_FUNC)-1:0]  cfg_slot,
  output logic [$clog2(REG_BYTES)-1:0]             cfg_reg,
  output logic [2:0]                               cfg_size,
  output logic                                     cfg_write,
  output logic [31:0]                              cfg_wdata,
  input  logic [31:0]                              cfg_rdata
);
  localparam int DEV_W  = $clog2(N_DEV);
  localparam int FUNC_W = $clog2(N_FUNC);
  localparam int REG_W  = $clog2(REG_BYTES);
  localparam int SLOT_W = DEV_W + FUNC_W;
  localparam int LAT    = LAT_CYC * CLK_RATIO;

  rtr_state_e        state_q;
  logic [DEV_W-1:0]  dec_dev;
  logic [FUNC_W-1:0] dec_func;
  logic [REG_W-1:0]  dec_reg;
  logic [SLOT_W-1:0] dec_slot;
  logic              hit;
  logic              accept;
  logic              ok_size;
  logic              fwd;
  logic              err_a;
  logic [31:0]       init_data;
  logic [31:0]       data_hold_q;
  logic [31:0]       data_next;
  logic              err_hold_q;
  logic              dly_done;

  cfgr_decode #(
    .ADDR_W  (ADDR_W),
    .DEV_W   (DEV_W),
    .FUNC_W  (FUNC_W),
    .REG_W   (REG_W),
    .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr(req_addr),
    .dev (dec_dev),
    .func(dec_func),
    .regb(dec_reg),
    .slot(dec_slot)
  );

  cfgr_presence #(.SLOT_W(SLOT_W)) u_pres (
    .clk     (clk),
    .rst     (rst),
    .set_en  (reg_valid),
    .set_slot({reg_dev, reg_func}),
    .rd_slot (dec_slot),
    .rd_hit  (hit)
  );

  cfgr_delay #(.LAT(LAT)) u_dly (
    .clk  (clk),
    .rst  (rst),
    .start(accept),
    .done (dly_done)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    ok_size   = size_legal(req_size);
    fwd       = ok_size && hit;
    err_a     = !ok_size || (req_write && !hit);
    init_data = (!ok_size || req_write || hit) ? 32'h0 : lane_mask(req_size);
    data_next = (cfg_valid && !cfg_write) ? (cfg_rdata & lane_mask(cfg_size))
                                          : data_hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cfg_valid   <= 1'b0;
      cfg_slot    <= '0;
      cfg_reg     <= '0;
      cfg_size    <= '0;
      cfg_write   <= 1'b0;
      cfg_wdata   <= '0;
      data_hold_q <= '0;
      err_hold_q  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_err     <= 1'b0;
    end else begin
      cfg_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cfg_valid   <= fwd;
            cfg_slot    <= dec_slot;
            cfg_reg     <= dec_reg;
            cfg_size    <= req_size;
            cfg_write   <= req_write;
            cfg_wdata   <= req_wdata & lane_mask(req_size);
            data_hold_q <= init_data;
            err_hold_q  <= err_a;
            state_q     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          data_hold_q <= data_next;
          if (dly_done) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= data_next;
            rsp_err   <= err_hold_q;
            state_q   <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker #(
  parameter int LAT    = 1,
  parameter int SLOT_W = 8,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              cfg_valid,
  input logic [SLOT_W-1:0] cfg_slot,
  input logic [REG_W-1:0]  cfg_reg,
  input logic [2:0]        cfg_size,
  input logic              cfg_write,
  input logic [31:0]       cfg_wdata
);
  localparam int LAT_EFF = (LAT < 1) ? 1 : LAT;

  int unsigned since_q;

  always_ff @(posedge clk) begin
    if (rst)
      since_q <= 0;
    else if (req_valid && req_ready)
      since_q <= 0;
    else if (since_q < 32'hFFFF_0000)
      since_q <= since_q + 1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !cfg_valid && req_ready));

  // R10
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && rsp_valid));

  // R4
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> !cfg_valid);

  // R6
  cmd_size_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (cfg_size == 3'd1 || cfg_size == 3'd2 || cfg_size == 3'd4));

  // R7
  wdata_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_write && cfg_size == 3'd1) |-> (cfg_wdata[31:8] == 24'h0));

  // R7
  wdata_half_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_write && cfg_size == 3'd2) |-> (cfg_wdata[31:16] == 16'h0));

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> (since_q == LAT_EFF));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R9
  rsp_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready) |=> !rsp_valid);

  // R2
  cmd_fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> ($stable(cfg_slot) && $stable(cfg_reg)));
endmodule

bind cfgspace_router cfgr_checker #(
  .LAT   (LAT_CYC * CLK_RATIO),
  .SLOT_W($clog2(N_DEV) + $clog2(N_FUNC)),
  .REG_W ($clog2(REG_BYTES))
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err),
  .cfg_valid(cfg_valid),
  .cfg_slot (cfg_slot),
  .cfg_reg  (cfg_reg),
  .cfg_size (cfg_size),
  .cfg_write(cfg_write),
  .cfg_wdata(cfg_wdata)
);

// File: tb/cfgspace_router_tb_top.sv
`timescale 1ns/1ps
module cfgspace_router_tb_top;
  localparam logic [31:0] BASE  = 32'h0008_0000;
  localparam int          LATC  = 2;
  localparam int          RATIO = 2;
  localparam int          D     = LATC * RATIO;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_valid = 1'b0;
  logic [4:0]  reg_dev = '0;
  logic [2:0]  reg_func = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        cfg_valid;
  logic [7:0]  cfg_slot;
  logic [7:0]  cfg_reg;
  logic [2:0]  cfg_size;
  logic        cfg_write;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;

  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [7:0] s, input logic [7:0] r);
    return {s, r, 8'h5A, s ^ r};
  endfunction

  function automatic logic [31:0] msk(input logic [2:0] sz);
    if (sz == 3'd1) return 32'hFF;
    if (sz == 3'd2) return 32'hFFFF;
    if (sz == 3'd4) return 32'hFFFF_FFFF;
    return 32'h0;
  endfunction

  // Slot responder driven by the bench.
  assign cfg_rdata = pat(cfg_slot, cfg_reg);

  cfgspace_router #(
    .WIN_BASE (BASE),
    .LAT_CYC  (LATC),
    .CLK_RATIO(RATIO)
  ) dut_i (
    .clk(clk), .rst(rst),
    .reg_valid(reg_valid), .reg_dev(reg_dev), .reg_func(reg_func),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err),
    .cfg_valid(cfg_valid), .cfg_slot(cfg_slot), .cfg_reg(cfg_reg),
    .cfg_size(cfg_size), .cfg_write(cfg_write), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference model.
  bit          pres_m [256];
  int          m_state = 0;
  int          m_left = 0;
  bit          in_reset = 1;
  logic        e_rsp_v = 0, e_cfg_v = 0, e_err = 0;
  logic [31:0] e_rdata = 0, e_wdata = 0;
  logic [7:0]  e_slot = 0, e_reg = 0;
  logic [2:0]  e_size = 0;
  logic        e_write = 0;
  string       e_tag = "R1";

  always @(posedge clk) begin
    logic [15:0] off;
    logic [7:0]  sl;
    bit          ok, hit;
    started = 1;
    if (rst) begin
      foreach (pres_m[i]) pres_m[i] = 0;
      m_state = 0; e_rsp_v = 0; e_cfg_v = 0; in_reset = 1;
    end else begin
      in_reset = 0;
      e_cfg_v = 0;
      case (m_state)
        0: if (req_valid) begin
          off = req_addr[15:0] - BASE[15:0];
          sl  = {off[15:11], off[10:8]};
          ok  = (req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4);
          hit = pres_m[sl];
          e_slot = sl; e_reg = off[7:0]; e_size = req_size; e_write = req_write;
          e_wdata = req_wdata & msk(req_size);
          e_cfg_v = ok && hit;
          e_err = !ok || (req_write && !hit);
          if (!ok) begin e_rdata = 0; e_tag = "R6"; end
          else if (req_write) begin e_rdata = 0; e_tag = hit ? "R7" : "R5"; end
          else if (hit) begin e_rdata = pat(sl, off[7:0]) & msk(req_size); e_tag = "R4"; end
          else begin e_rdata = msk(req_size); e_tag = "R3"; end
          m_left = D; m_state = 1;
        end
        1: begin
          m_left--;
          if (m_left == 0) begin m_state = 2; e_rsp_v = 1; end
        end
        default: if (rsp_ready) begin e_rsp_v = 0; m_state = 0; end
      endcase
      // R11: lookup above uses the old table; the set lands after it.
      if (reg_valid) pres_m[{reg_dev, reg_func}] = 1;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (started && !finished) begin
      chk(in_reset ? "R1 ready" : "R10 ready", {31'h0, req_ready}, {31'h0, m_state == 0});
      chk(in_reset ? "R1 rsp_valid" : "R8 rsp_valid", {31'h0, rsp_valid}, {31'h0, e_rsp_v});
      chk(in_reset ? "R1 cfg_valid" : {e_tag, " cfg_valid"}, {31'h0, cfg_valid}, {31'h0, e_cfg_v});
      if (e_rsp_v && !in_reset) begin
        chk({e_tag, "/R9 rdata"}, rsp_rdata, e_rdata);
        chk({e_tag, "/R9 err"}, {31'h0, rsp_err}, {31'h0, e_err});
      end
      if (e_cfg_v && cfg_valid) begin
        chk("R2 slot", {24'h0, cfg_slot}, {24'h0, e_slot});
        chk("R2 reg", {24'h0, cfg_reg}, {24'h0, e_reg});
        chk({e_tag, " size"}, {29'h0, cfg_size}, {29'h0, e_size});
        chk({e_tag, " write"}, {31'h0, cfg_write}, {31'h0, e_write});
        if (e_write) chk("R7 wdata", cfg_wdata, e_wdata);
      end
    end
  end

  function automatic logic [31:0] mk_addr(input int dv, input int fn, input int rg);
    return BASE + ((dv & 31) << 11) + ((fn & 7) << 8) + (rg & 255);
  endfunction

  task automatic access(input logic [31:0] a, input logic [2:0] sz, input logic wr,
                        input logic [31:0] wd, input int hold,
                        input bit with_reg, input int rdv, input int rfn);
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    if (with_reg) begin reg_valid = 1'b1; reg_dev = 5'(rdv); reg_func = 3'(rfn); end
    @(negedge clk);
    req_valid = 1'b0; reg_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic register_slot(input int dv, input int fn);
    @(negedge clk);
    reg_valid = 1'b1; reg_dev = 5'(dv); reg_func = 3'(fn);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3: empty slots read all-ones by width
    access(mk_addr(3, 5, 8'h10), 3'd1, 0, 0, 0, 0, 0, 0);
    access(mk_addr(3, 5, 8'h10), 3'd2, 0, 0, 1, 0, 0, 0);
    access(mk_addr(3, 5, 8'h10), 3'd4, 0, 0, 0, 0, 0, 0);
    // R5: write to empty slot
    access(mk_addr(7, 1, 8'h04), 3'd4, 1, 32'hDEAD_BEEF, 2, 0, 0, 0);
    // R11: register on the same edge as a read of that slot
    access(mk_addr(3, 5, 8'h22), 3'd4, 0, 0, 0, 1, 3, 5);
    access(mk_addr(3, 5, 8'h22), 3'd4, 0, 0, 0, 0, 0, 0);
    register_slot(31, 7);
    register_slot(0, 0);
    // R4 / R2: present reads of each size, corner slots
    access(mk_addr(31, 7, 8'hFF), 3'd1, 0, 0, 3, 0, 0, 0);
    access(mk_addr(31, 7, 8'hFE), 3'd2, 0, 0, 0, 0, 0, 0);
    access(mk_addr(0, 0, 8'h00), 3'd4, 0, 0, 5, 0, 0, 0);
    // R7: present writes with lane masking
    access(mk_addr(0, 0, 8'h3C), 3'd1, 1, 32'h1234_5678, 0, 0, 0, 0);
    access(mk_addr(31, 7, 8'h40), 3'd2, 1, 32'hCAFE_F00D, 1, 0, 0, 0);
    access(mk_addr(3, 5, 8'h44), 3'd4, 1, 32'hA5A5_0F0F, 0, 0, 0, 0);
    // R6: illegal sizes, present and absent, read and write
    access(mk_addr(0, 0, 8'h08), 3'd3, 0, 0, 0, 0, 0, 0);
    access(mk_addr(0, 0, 8'h08), 3'd0, 1, 32'h1, 0, 0, 0, 0);
    access(mk_addr(9, 2, 8'h08), 3'd7, 0, 0, 2, 0, 0, 0);
    // Sweep of mixed slots and sizes
    for (int i = 0; i < 24; i++) begin
      if (i % 3 == 0) register_slot((i * 5) % 32, i % 8);
      access(mk_addr((i * 5) % 32, i % 8, i * 11), (i % 3 == 0) ? 3'd1 : (i % 3 == 1) ? 3'd2 : 3'd4,
             (i % 4) == 3, 32'h0102_0304 * (i + 1), i % 3, 0, 0, 0);
    end
    // R1: reset clears presence
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    access(mk_addr(31, 7, 8'h00), 3'd4, 0, 0, 0, 0, 0, 0);
    access(mk_addr(0, 0, 8'h00), 3'd2, 1, 32'h55, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule